// File: doc/BRIEF.md
# Keyed Watchdog Timer

This block is a 32-bit watchdog counter. Software programs it through a small register bus that accepts 32-bit and 16-bit accesses. While it runs, the counter climbs once per prescaler tick. When the counter wraps past its all-ones value, the block raises a one-cycle reset pulse and reloads the counter from the load register. Software keeps the system alive by writing the trigger register often enough. Each trigger write reloads the counter early.

The run state is guarded. The watchdog stops only after two ordered key writes to the key register, and it starts only after a different pair of key writes. The counter, the load value and the prescaler settings can be changed only while the watchdog is stopped. A new prescaler setting does not reach the counting logic when it is written. It is applied at the next overflow or the next trigger write.

The block leaves reset stopped, with every register at zero. A system programs the load value and the prescaler first, then starts the watchdog with the start key pair.

Top module: `wdt_keyed`

## Requirements
- R1: After reset the watchdog is stopped, the reset pulse is low, and the counter, load and control registers all read zero.
- R2: Register addresses are 0 control, 1 counter, 2 load, 3 trigger and 4 key. With `bus_wide`=1 an access covers all 32 bits. With `bus_wide`=0 an access covers one half: the high half when `bus_upper`=1, the low half otherwise. The data travels on bits 15:0, and read bits 31:16 are zero.
- R3: A key-register write whose low 16 bits are 0xAAAA, followed directly by a key-register write whose low 16 bits are 0x5555, stops the watchdog. The upper 16 bits of both writes are ignored.
- R4: A key write of 0xBBBB followed directly by a key write of 0x4444 starts the watchdog. The run state changes on the clock edge of the second write.
- R5: Any other sequence of key writes leaves the run state unchanged. A key write that is not the awaited second key cancels the pending first key, and a 16-bit write to the high half of the key register counts as such a write. A first-key write always begins a new sequence.
- R6: While the watchdog runs, writes to the counter, load and control registers are ignored. While it is stopped, such writes take effect on the next clock edge, and 16-bit writes alter only their own half.
- R7: While running, the counter increases by one on each prescaler tick. While stopped, it holds its value.
- R8: Control bit 3 enables the prescaler and bits 2:0 hold the ratio p. With the prescaler enabled, a tick occurs every 2^p clocks, counted from the last trigger or overflow. With the prescaler disabled, a tick occurs every clock.
- R9: A control value written while stopped is applied to the prescaler only at the next overflow or trigger write. Until then, counting keeps the previously applied setting.
- R10: When a tick arrives with the counter at 0xFFFFFFFF, the counter loads the load-register value and `wdt_reset_o` is high for exactly the following cycle.
- R11: A trigger-register write while running reloads the counter from the load register, applies the control value and restarts the prescaler phase. A trigger write while stopped has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Access strobe |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_wide | input | 1 | 1 = 32-bit access, 0 = 16-bit access |
| bus_upper | input | 1 | Half select for 16-bit accesses (1 = high half) |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational |
| wdt_reset_o | output | 1 | One-cycle pulse on counter wrap |

## Verification
The assertions watch every cycle for the following:
- the run state moves only on a key write, and only after the matching second key;
- the reset pulse lasts one cycle and follows a wrap from all ones;
- the load and control registers stay locked while the watchdog runs;
- the counter stays still while stopped unless it is written directly.

The bench scenarios cover what needs a known history:
- exact counts after chosen numbers of prescaled ticks, across the prescaler ratios;
- deferral of a new control value until the next trigger;
- the reload value at overflow;
- broken or restarted key sequences that leave the watchdog running.

// File: rtl/wdt_keyed_pkg.sv
package wdt_keyed_pkg;

    localparam int WORD_W = 32;
    localparam int HALF_W = 16;

    typedef enum logic [2:0] {
        REG_CTRL  = 3'd0,
        REG_COUNT = 3'd1,
        REG_LOAD  = 3'd2,
        REG_TRIG  = 3'd3,
        REG_KEY   = 3'd4
    } reg_sel_e;

    typedef enum logic [1:0] {
        KEY_IDLE       = 2'd0,
        KEY_HALF_STOP  = 2'd1,
        KEY_HALF_START = 2'd2
    } key_state_e;

    localparam logic [HALF_W-1:0] STOP_KEY_A  = 16'hAAAA;
    localparam logic [HALF_W-1:0] STOP_KEY_B  = 16'h5555;
    localparam logic [HALF_W-1:0] START_KEY_A = 16'hBBBB;
    localparam logic [HALF_W-1:0] START_KEY_B = 16'h4444;

    // Combine a full or half-word write with the current register contents.
    function automatic logic [WORD_W-1:0] merge_write(
        input logic [WORD_W-1:0] old_val,
        input logic [WORD_W-1:0] wdata,
        input logic              wide,
        input logic              upper
    );
        if (wide)       return wdata;
        else if (upper) return {wdata[HALF_W-1:0], old_val[HALF_W-1:0]};
        else            return {old_val[WORD_W-1:HALF_W], wdata[HALF_W-1:0]};
    endfunction

endpackage

// File: rtl/wdt_key_seq.sv
module wdt_key_seq
    import wdt_keyed_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic              low_ok,
    input  logic [HALF_W-1:0] val,
    output logic              run
);

    key_state_e state_q, state_d;
    logic       run_d;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= KEY_IDLE;
            run     <= 1'b0;
        end else begin
            state_q <= state_d;
            run     <= run_d;
        end
    end

    always_comb begin
        state_d = state_q;
        run_d   = run;
        if (wr) begin
            state_d = KEY_IDLE;
            if (low_ok) begin
                unique case (state_q)
                    KEY_IDLE:       ;
                    KEY_HALF_STOP:  if (val == STOP_KEY_B)  run_d = 1'b0;
                    KEY_HALF_START: if (val == START_KEY_B) run_d = 1'b1;
                    default:        ;
                endcase
                if (val == STOP_KEY_A)       state_d = KEY_HALF_STOP;
                else if (val == START_KEY_A) state_d = KEY_HALF_START;
            end
        end
    end

endmodule

// File: rtl/wdt_prescale.sv
module wdt_prescale #(
    parameter int PTV_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             apply,
    input  logic             new_en,
    input  logic [PTV_W-1:0] new_ptv,
    output logic             tick
);

    localparam int DIV_W = (1 << PTV_W) - 1;

    logic             act_en;
    logic [PTV_W-1:0] act_ptv;
    logic [DIV_W-1:0] div_q;
    logic [DIV_W-1:0] div_mask;
    logic             div_end;

    assign div_mask = (DIV_W'(1) << act_ptv) - DIV_W'(1);
    assign div_end  = (div_q == div_mask);
    assign tick     = run && (!act_en || div_end);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_en  <= 1'b0;
            act_ptv <= '0;
            div_q   <= '0;
        end else if (apply) begin
            act_en  <= new_en;
            act_ptv <= new_ptv;
            div_q   <= '0;
        end else if (run && act_en) begin
            div_q <= div_end ? '0 : div_q + DIV_W'(1);
        end
    end

endmodule

// File: rtl/wdt_count.sv
module wdt_count #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             tick,
    input  logic             trig,
    input  logic [CNT_W-1:0] load_val,
    input  logic             cwr,
    input  logic [CNT_W-1:0] cwr_val,
    output logic [CNT_W-1:0] count,
    output logic             ovf_evt,
    output logic             pulse_o
);

    assign ovf_evt = run && tick && !trig && (count == {CNT_W{1'b1}});

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count   <= '0;
            pulse_o <= 1'b0;
        end else begin
            pulse_o <= 1'b0;
            if (trig) begin
                count <= load_val;
            end else if (ovf_evt) begin
                count   <= load_val;
                pulse_o <= 1'b1;
            end else if (run && tick) begin
                count <= count + CNT_W'(1);
            end else if (!run && cwr) begin
                count <= cwr_val;
            end
        end
    end

endmodule

// File: rtl/wdt_keyed.sv
module wdt_keyed
    import wdt_keyed_pkg::*;
#(
    parameter int PTV_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_we,
    input  logic              bus_wide,
    input  logic              bus_upper,
    input  logic [2:0]        bus_addr,
    input  logic [WORD_W-1:0] bus_wdata,
    output logic [WORD_W-1:0] bus_rdata,
    output logic              wdt_reset_o
);

    localparam int CTL_W = PTV_W + 1;

    reg_sel_e          reg_sel;
    logic              wr;
    logic              run_w;
    logic              tick_w;
    logic              ovf_w;
    logic              trig_apply;
    logic              apply_w;
    logic [CTL_W-1:0]  ctrl_q;
    logic [WORD_W-1:0] load_q;
    logic [WORD_W-1:0] count_w;
    logic [WORD_W-1:0] ctrl_merged;
    logic [WORD_W-1:0] word_rd;

    assign reg_sel     = reg_sel_e'(bus_addr);
    assign wr          = bus_sel && bus_we;
    assign trig_apply  = wr && (reg_sel == REG_TRIG) && run_w;
    assign apply_w     = trig_apply || ovf_w;
    assign ctrl_merged = merge_write(WORD_W'(ctrl_q), bus_wdata, bus_wide, bus_upper);

    // Configuration registers: writable only while stopped.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= '0;
            load_q <= '0;
        end else if (wr && !run_w) begin
            if (reg_sel == REG_CTRL) ctrl_q <= ctrl_merged[CTL_W-1:0];
            if (reg_sel == REG_LOAD) load_q <= merge_write(load_q, bus_wdata, bus_wide, bus_upper);
        end
    end

    wdt_key_seq u_key (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr     (wr && (reg_sel == REG_KEY)),
        .low_ok (bus_wide || !bus_upper),
        .val    (bus_wdata[HALF_W-1:0]),
        .run    (run_w)
    );

    wdt_prescale #(.PTV_W(PTV_W)) u_pre (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (run_w),
        .apply   (apply_w),
        .new_en  (ctrl_q[PTV_W]),
        .new_ptv (ctrl_q[PTV_W-1:0]),
        .tick    (tick_w)
    );

    wdt_count #(.CNT_W(WORD_W)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (run_w),
        .tick     (tick_w),
        .trig     (trig_apply),
        .load_val (load_q),
        .cwr      (wr && (reg_sel == REG_COUNT)),
        .cwr_val  (merge_write(count_w, bus_wdata, bus_wide, bus_upper)),
        .count    (count_w),
        .ovf_evt  (ovf_w),
        .pulse_o  (wdt_reset_o)
    );

    always_comb begin
        unique case (reg_sel)
            REG_CTRL:  word_rd = WORD_W'(ctrl_q);
            REG_COUNT: word_rd = count_w;
            REG_LOAD:  word_rd = load_q;
            default:   word_rd = '0;
        endcase
        if (bus_wide)       bus_rdata = word_rd;
        else if (bus_upper) bus_rdata = {{HALF_W{1'b0}}, word_rd[WORD_W-1:HALF_W]};
        else                bus_rdata = {{HALF_W{1'b0}}, word_rd[HALF_W-1:0]};
    end

endmodule

// File: rtl/wdt_keyed_chk.sv
module wdt_keyed_chk #(
    parameter int CTL_W = 4
) (
    input logic        clk,
    input logic        rst_n,
    input logic        bus_sel,
    input logic        bus_we,
    input logic        bus_wide,
    input logic        bus_upper,
    input logic [2:0]  bus_addr,
    input logic [31:0] bus_wdata,
    input logic        run,
    input logic [31:0] count,
    input logic [31:0] load,
    input logic [CTL_W-1:0] ctrl,
    input logic        rst_o
);

    logic wr_any, key_any, key_low, wr_count, wr_load, wr_ctrl;

    assign wr_any   = bus_sel && bus_we;
    assign key_any  = wr_any && (bus_addr == 3'd4);
    assign key_low  = key_any && (bus_wide || !bus_upper);
    assign wr_count = wr_any && (bus_addr == 3'd1);
    assign wr_load  = wr_any && (bus_addr == 3'd2);
    assign wr_ctrl  = wr_any && (bus_addr == 3'd0);

    a_r10_pulse_single: assert property (@(posedge clk) disable iff (!rst_n)
        rst_o |=> !rst_o);

    a_r10_pulse_after_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        rst_o |-> $past(run && count == 32'hFFFF_FFFF));

    a_r4_start_needs_key: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(run) |-> $past(key_low && bus_wdata[15:0] == 16'h4444));

    a_r3_stop_needs_key: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(run) |-> $past(key_low && bus_wdata[15:0] == 16'h5555));

    a_r5_run_holds: assert property (@(posedge clk) disable iff (!rst_n)
        !key_any |=> $stable(run));

    a_r6_load_locked: assert property (@(posedge clk) disable iff (!rst_n)
        (run && wr_load) |=> $stable(load));

    a_r6_ctrl_locked: assert property (@(posedge clk) disable iff (!rst_n)
        (run && wr_ctrl) |=> $stable(ctrl));

    a_r7_stopped_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !wr_count) |=> $stable(count));

endmodule

bind wdt_keyed wdt_keyed_chk #(.CTL_W(PTV_W + 1)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_sel   (bus_sel),
    .bus_we    (bus_we),
    .bus_wide  (bus_wide),
    .bus_upper (bus_upper),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .run       (run_w),
    .count     (count_w),
    .load      (load_q),
    .ctrl      (ctrl_q),
    .rst_o     (wdt_reset_o)
);

// File: tb/wdt_keyed_test.sv
`timescale 1ns/1ps
module wdt_keyed_test;

    localparam time CLK_P = 20ns;
    localparam logic [2:0] A_CTRL = 3'd0, A_COUNT = 3'd1, A_LOAD = 3'd2,
                           A_TRIG = 3'd3, A_KEY = 3'd4;
    localparam logic [31:0] L = 32'h1234_5678;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0, bus_we = 1'b0, bus_wide = 1'b1, bus_upper = 1'b0;
    logic [2:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        wdt_reset_o;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #(CLK_P/2) clk = ~clk;

    wdt_keyed uut (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
        .bus_wide(bus_wide), .bus_upper(bus_upper), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .wdt_reset_o(wdt_reset_o)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic wide, input logic up, input logic [31:0] d);
        bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a;
        bus_wide = wide; bus_upper = up; bus_wdata = d;
        @(posedge clk);
        @(negedge clk);
        bus_sel = 1'b0; bus_we = 1'b0; bus_wide = 1'b1; bus_upper = 1'b0;
    endtask

    task automatic wr32(input logic [2:0] a, input logic [31:0] d);
        wr(a, 1'b1, 1'b0, d);
    endtask

    task automatic rd(input logic [2:0] a, input logic wide, input logic up, output logic [31:0] d);
        bus_addr = a; bus_wide = wide; bus_upper = up;
        #1;
        d = bus_rdata;
        bus_wide = 1'b1; bus_upper = 1'b0;
    endtask

    task automatic waitn(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic stop_wd();
        wr32(A_KEY, 32'h0000_AAAA);
        wr32(A_KEY, 32'h0000_5555);
    endtask

    task automatic start_wd();
        wr32(A_KEY, 32'h0000_BBBB);
        wr32(A_KEY, 32'h0000_4444);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        rd(A_COUNT, 1, 0, v); check("R1 count", v, 32'h0);
        rd(A_LOAD, 1, 0, v);  check("R1 load", v, 32'h0);
        rd(A_CTRL, 1, 0, v);  check("R1 ctrl", v, 32'h0);
        check("R1 reset_o", {31'b0, wdt_reset_o}, 32'h0);
        // R11 trigger while stopped; R7 hold while stopped
        wr32(A_TRIG, 32'h1);
        rd(A_COUNT, 1, 0, v); check("R11 trig stopped", v, 32'h0);
        waitn(5);
        rd(A_COUNT, 1, 0, v); check("R7 stopped hold", v, 32'h0);

        // R2 half-word access
        wr(A_LOAD, 0, 0, 32'h0000_5678);
        wr(A_LOAD, 0, 1, 32'h0000_1234);
        rd(A_LOAD, 1, 0, v); check("R2 load 32", v, L);
        rd(A_LOAD, 0, 1, v); check("R2 load hi16", v, 32'h0000_1234);
        rd(A_LOAD, 0, 0, v); check("R2 load lo16", v, 32'h0000_5678);
        wr32(A_COUNT, 32'hFFFF_FFF0);
        rd(A_COUNT, 1, 0, v); check("R6 count stopped write", v, 32'hFFFF_FFF0);

        // R4 start, R7 counting, R10 overflow
        start_wd();
        waitn(15);
        rd(A_COUNT, 1, 0, v); check("R7 count run", v, 32'hFFFF_FFFF);
        check("R10 no early pulse", {31'b0, wdt_reset_o}, 32'h0);
        waitn(1);
        rd(A_COUNT, 1, 0, v); check("R10 reload", v, L);
        check("R10 pulse high", {31'b0, wdt_reset_o}, 32'h1);
        waitn(1);
        check("R10 pulse one cycle", {31'b0, wdt_reset_o}, 32'h0);
        rd(A_COUNT, 1, 0, v); check("R4 running after wrap", v, L + 1);

        // R6 writes ignored while running, R11 trigger
        wr32(A_COUNT, 32'h0);
        wr32(A_LOAD, 32'hAAAA_0000);
        wr32(A_CTRL, 32'hF);
        rd(A_CTRL, 1, 0, v); check("R6 ctrl locked", v, 32'h0);
        rd(A_LOAD, 1, 0, v); check("R6 load locked", v, L);
        wr32(A_TRIG, 32'h0);
        rd(A_COUNT, 1, 0, v); check("R11 trig reload", v, L);
        waitn(3);
        rd(A_COUNT, 1, 0, v); check("R7 after trig", v, L + 3);

        // R5 broken sequences
        wr32(A_TRIG, 32'h0);
        wr32(A_KEY, 32'hAAAA); wr32(A_KEY, 32'h1234); wr32(A_KEY, 32'h5555);
        waitn(2);
        rd(A_COUNT, 1, 0, v); check("R5 interrupted stop", v, L + 5);
        wr32(A_TRIG, 32'h0);
        wr32(A_KEY, 32'hAAAA); wr(A_KEY, 0, 1, 32'h5555); wr32(A_KEY, 32'h5555);
        waitn(2);
        rd(A_COUNT, 1, 0, v); check("R5 high-half write breaks", v, L + 5);
        wr32(A_TRIG, 32'h0);
        wr32(A_KEY, 32'hBBBB); wr32(A_KEY, 32'h5555);
        waitn(2);
        rd(A_COUNT, 1, 0, v); check("R5 mixed keys", v, L + 4);

        // R3 stop with don't-care upper bits
        wr32(A_TRIG, 32'h0);
        wr32(A_KEY, 32'h1234_AAAA); wr32(A_KEY, 32'hFFFF_5555);
        rd(A_COUNT, 1, 0, v); check("R3 stop edge", v, L + 2);
        waitn(5);
        rd(A_COUNT, 1, 0, v); check("R3 stopped", v, L + 2);

        // R5 fresh first key restarts the sequence
        wr32(A_KEY, 32'hBBBB); wr32(A_KEY, 32'hAAAA);
        wr32(A_KEY, 32'hBBBB); wr32(A_KEY, 32'h4444);
        waitn(4);
        rd(A_COUNT, 1, 0, v); check("R5 restarted start", v, L + 6);

        // R9 deferral of control value
        stop_wd();
        wr32(A_CTRL, 32'hA);
        wr32(A_COUNT, 32'd100);
        rd(A_CTRL, 1, 0, v); check("R6 ctrl stopped write", v, 32'hA);
        start_wd();
        waitn(8);
        rd(A_COUNT, 1, 0, v); check("R9 old setting kept", v, 32'd108);
        wr32(A_TRIG, 32'h0);
        waitn(8);
        rd(A_COUNT, 1, 0, v); check("R9 applied at trigger", v, L + 2);

        // R8 prescaler sweep
        for (int p = 0; p < 6; p++) begin
            logic [31:0] ld;
            logic [31:0] c;
            ld = 32'h1000 * p + 32'h10;
            c  = (p == 5) ? 32'h3 : (32'h8 | p);
            stop_wd();
            wr32(A_CTRL, c);
            wr32(A_LOAD, ld);
            start_wd();
            wr32(A_TRIG, 32'h0);
            waitn(32);
            rd(A_COUNT, 1, 0, v);
            check($sformatf("R8 ratio ctrl=%0h", c), v, ld + ((p == 5) ? 32 : (32 >> p)));
        end

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule